// File: doc/BRIEF.md
# Host Mailbox Transaction Sequencer

This block runs one complete mailbox exchange with a remote management agent through a byte-wide register port. The host side hands it a request: an 8-bit command, a flag that says whether a result is expected back, and a 32-bit argument. The block then issues every register access the exchange needs, in a fixed order. It waits for the agent to flag completion and collects the 32-bit answer when one is expected. It then acknowledges the completion flag and reports the outcome through a one-cycle done strobe, an error flag and a result word.

The register port is a simple request/acknowledge interface. The sequencer holds an access steady until the port acknowledges it, and the port returns read data and a bus-error flag together with that acknowledge. A separate one-shot arm request runs the alert-enable step, which clears the alert mask bit in the control register only when it is set. Typical command values are 0x01 (read power draw), 0x02 (set power cap), 0x03 (read power cap) and 0x04 (read the highest allowed cap). The block passes the command through without decoding it, so the caller decides the read flag.

Top module: `mbox_seq`

## Requirements
- R1: After reset, req_ready is 1, done, err and rdata are 0, and no register access is issued.
- R2: A request or arm pulse is taken only while req_ready is 1. A req_valid pulse during a running exchange starts no further accesses, either during that exchange or after it.
- R3: An access holds reg_valid, reg_addr, reg_write and reg_wdata steady until the cycle in which reg_ack is 1. Each access is carried out exactly once.
- R4: Every exchange, read or write, begins with these writes in order: 0x80 to 0x3F, the command to 0x38, the argument bytes least significant first to 0x39, 0x3A, 0x3B and 0x3C, and then 0x01 to 0x40.
- R5: The block then reads status address 0x02, where bit 1 marks completion. After a read with bit 1 clear, exactly POLL_WAIT+1 cycles pass with no access before the next status read.
- R6: If POLL_RETRIES+1 status reads in a row all show bit 1 clear, the exchange ends with err=1. No outbound read and no clear write are issued.
- R7: In a read exchange, after completion the block reads 0x31, 0x32, 0x33 and 0x34 in that order, and rdata becomes {byte@0x34, byte@0x33, byte@0x32, byte@0x31}.
- R8: A write exchange issues no outbound reads, and its rdata is 0.
- R9: The last access of a successful exchange writes the completing status value with bit 1 forced to 1 to address 0x02. The exchange then ends with err=0.
- R10: When an access is acknowledged with reg_err=1, done and err are 1 in the next cycle and no further access follows.
- R11: The arm sequence reads control address 0x01. Only when bit 4 of that value is 1 does it write the value back to 0x01 with bit 4 cleared. It ends with done and err=0 unless the port reports an error.
- R12: done is a single-cycle pulse. err and rdata keep their values until the next request is accepted.
- R13: When arm_req and req_valid are both 1 in an idle cycle, the arm sequence is taken and the request is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start an exchange (taken when idle) |
| req_ready | output | 1 | Sequencer is idle |
| req_cmd | input | 8 | Command code |
| req_read | input | 1 | Exchange returns a result word |
| req_wdata | input | 32 | Argument word |
| arm_req | input | 1 | Run the alert-enable sequence (taken when idle) |
| reg_valid | output | 1 | Register access pending |
| reg_write | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 8 | Write data |
| reg_ack | input | 1 | Access completes this cycle |
| reg_rdata | input | 8 | Read data, valid with reg_ack |
| reg_err | input | 1 | Bus error, valid with reg_ack |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Last exchange failed |
| rdata | output | 32 | Result word of the last read exchange |

## Verification
On every cycle the assertions check the port discipline and the local rules: access stability until acknowledge, no access while idle, the fixed values written to the start and doorbell addresses, bit 1 set in every status write, bit 4 clear in every control write, the error-to-done response, the single-cycle done, and a cap on status reads per exchange. The full order of accesses, the exact poll spacing, the result word assembled from the outbound bytes, the timeout path and the dropped requests can only be shown by the bench. It records the access trace from a responder model and compares it with a sequence computed from the requirements, over every command, every completion point and every error-injection position.

// File: rtl/mbox_seq_pkg.sv
package mbox_seq_pkg;

    localparam int BYTE_W     = 8;
    localparam int REG_AW     = 8;
    localparam int WORD_BYTES = 4;

    // register addresses whose values the remote agent decodes
    localparam logic [REG_AW-1:0] A_CTRL     = 8'h01;
    localparam logic [REG_AW-1:0] A_STAT     = 8'h02;
    localparam logic [REG_AW-1:0] A_OUT_LO   = 8'h31;
    localparam logic [REG_AW-1:0] A_IN_CMD   = 8'h38;
    localparam logic [REG_AW-1:0] A_IN_LO    = 8'h39;
    localparam logic [REG_AW-1:0] A_IN_START = 8'h3F;
    localparam logic [REG_AW-1:0] A_RING     = 8'h40;

    localparam logic [BYTE_W-1:0] V_START = 8'h80;
    localparam logic [BYTE_W-1:0] V_RING  = 8'h01;

    localparam int STAT_DONE_BIT = 1;
    localparam int CTRL_MASK_BIT = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ARM_RD,
        ST_ARM_WR,
        ST_START,
        ST_CMD,
        ST_ARG,
        ST_RING,
        ST_POLL,
        ST_WAIT,
        ST_OUT,
        ST_CLEAR
    } seq_state_e;

endpackage

// File: rtl/mbox_seq_timer.sv
module mbox_seq_timer #(
    parameter int POLL_WAIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int CNT_W = $clog2(POLL_WAIT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CNT_W'(POLL_WAIT);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/mbox_seq_collect.sv
module mbox_seq_collect #(
    parameter int LANE_W = 8,
    parameter int LANES  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      load,
    input  logic [$clog2(LANES)-1:0]  lane_sel,
    input  logic [LANE_W-1:0]         lane_in,
    output logic [LANE_W*LANES-1:0]   word_out
);
    localparam int SEL_W = $clog2(LANES);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_d, lane_q;

        always_comb begin
            lane_d = lane_q;
            if (clear) begin
                lane_d = '0;
            end else if (load && (lane_sel == SEL_W'(g))) begin
                lane_d = lane_in;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else begin
                lane_q <= lane_d;
            end
        end

        assign word_out[g*LANE_W +: LANE_W] = lane_q;
    end
endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
    import mbox_seq_pkg::*;
#(
    parameter int POLL_RETRIES = 10,
    parameter int POLL_WAIT    = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic [BYTE_W-1:0]              req_cmd,
    input  logic                           req_read,
    input  logic [BYTE_W*WORD_BYTES-1:0]   req_wdata,
    input  logic                           arm_req,
    output logic                           reg_valid,
    output logic                           reg_write,
    output logic [REG_AW-1:0]              reg_addr,
    output logic [BYTE_W-1:0]              reg_wdata,
    input  logic                           reg_ack,
    input  logic [BYTE_W-1:0]              reg_rdata,
    input  logic                           reg_err,
    output logic                           done,
    output logic                           err,
    output logic [BYTE_W*WORD_BYTES-1:0]   rdata
);
    localparam int WORD_W = BYTE_W * WORD_BYTES;
    localparam int IDX_W  = $clog2(WORD_BYTES);
    localparam int POLL_W = $clog2(POLL_RETRIES + 1);
    localparam logic [IDX_W-1:0]  IDX_LAST   = IDX_W'(WORD_BYTES - 1);
    localparam logic [POLL_W-1:0] POLL_LAST  = POLL_W'(POLL_RETRIES);
    localparam logic [BYTE_W-1:0] DONE_MASK  = BYTE_W'(1) << STAT_DONE_BIT;
    localparam logic [BYTE_W-1:0] CTRL_MASK  = BYTE_W'(1) << CTRL_MASK_BIT;

    typedef struct packed {
        seq_state_e          state;
        logic [IDX_W-1:0]    idx;
        logic [POLL_W-1:0]   polls;
        logic [BYTE_W-1:0]   stat;
        logic [BYTE_W-1:0]   ctrl;
        logic [BYTE_W-1:0]   cmd;
        logic                rd;
        logic [WORD_W-1:0]   arg;
        logic                done;
        logic                err;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              tmr_start, tmr_expired;
    logic              col_clear, col_load;
    logic              acc_valid, acc_write;
    logic [REG_AW-1:0] acc_addr;
    logic [BYTE_W-1:0] acc_data;
    logic              xfer_ok, xfer_bad;

    mbox_seq_timer #(
        .POLL_WAIT (POLL_WAIT)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .expired (tmr_expired)
    );

    mbox_seq_collect #(
        .LANE_W (BYTE_W),
        .LANES  (WORD_BYTES)
    ) collect_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (col_clear),
        .load     (col_load),
        .lane_sel (seq_q.idx),
        .lane_in  (reg_rdata),
        .word_out (rdata)
    );

    // access decode from the registered state
    always_comb begin
        acc_valid = 1'b0;
        acc_write = 1'b0;
        acc_addr  = '0;
        acc_data  = '0;
        unique case (seq_q.state)
            ST_ARM_RD: begin
                acc_valid = 1'b1;
                acc_addr  = A_CTRL;
            end
            ST_ARM_WR: begin
                acc_valid = 1'b1;
                acc_write = 1'b1;
                acc_addr  = A_CTRL;
                acc_data  = seq_q.ctrl & ~CTRL_MASK;
            end
            ST_START: begin
                acc_valid = 1'b1;
                acc_write = 1'b1;
                acc_addr  = A_IN_START;
                acc_data  = V_START;
            end
            ST_CMD: begin
                acc_valid = 1'b1;
                acc_write = 1'b1;
                acc_addr  = A_IN_CMD;
                acc_data  = seq_q.cmd;
            end
            ST_ARG: begin
                acc_valid = 1'b1;
                acc_write = 1'b1;
                acc_addr  = A_IN_LO + REG_AW'(seq_q.idx);
                acc_data  = seq_q.arg[BYTE_W*seq_q.idx +: BYTE_W];
            end
            ST_RING: begin
                acc_valid = 1'b1;
                acc_write = 1'b1;
                acc_addr  = A_RING;
                acc_data  = V_RING;
            end
            ST_POLL: begin
                acc_valid = 1'b1;
                acc_addr  = A_STAT;
            end
            ST_OUT: begin
                acc_valid = 1'b1;
                acc_addr  = A_OUT_LO + REG_AW'(seq_q.idx);
            end
            ST_CLEAR: begin
                acc_valid = 1'b1;
                acc_write = 1'b1;
                acc_addr  = A_STAT;
                acc_data  = seq_q.stat | DONE_MASK;
            end
            default: ;
        endcase
    end

    assign xfer_ok  = acc_valid && reg_ack && !reg_err;
    assign xfer_bad = acc_valid && reg_ack && reg_err;

    // next-state computation
    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        tmr_start  = 1'b0;
        col_clear  = 1'b0;
        col_load   = 1'b0;

        unique case (seq_q.state)
            ST_IDLE: begin
                if (arm_req) begin
                    seq_d.state = ST_ARM_RD;
                    seq_d.err   = 1'b0;
                end else if (req_valid) begin
                    seq_d.state = ST_START;
                    seq_d.err   = 1'b0;
                    seq_d.cmd   = req_cmd;
                    seq_d.rd    = req_read;
                    seq_d.arg   = req_wdata;
                    seq_d.idx   = '0;
                    seq_d.polls = '0;
                    col_clear   = 1'b1;
                end
            end
            ST_ARM_RD: begin
                if (xfer_ok) begin
                    if (reg_rdata[CTRL_MASK_BIT]) begin
                        seq_d.ctrl  = reg_rdata;
                        seq_d.state = ST_ARM_WR;
                    end else begin
                        seq_d.state = ST_IDLE;
                        seq_d.done  = 1'b1;
                    end
                end
            end
            ST_ARM_WR: begin
                if (xfer_ok) begin
                    seq_d.state = ST_IDLE;
                    seq_d.done  = 1'b1;
                end
            end
            ST_START: begin
                if (xfer_ok) seq_d.state = ST_CMD;
            end
            ST_CMD: begin
                if (xfer_ok) begin
                    seq_d.state = ST_ARG;
                    seq_d.idx   = '0;
                end
            end
            ST_ARG: begin
                if (xfer_ok) begin
                    if (seq_q.idx == IDX_LAST) begin
                        seq_d.state = ST_RING;
                        seq_d.idx   = '0;
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end
                end
            end
            ST_RING: begin
                if (xfer_ok) seq_d.state = ST_POLL;
            end
            ST_POLL: begin
                if (xfer_ok) begin
                    if (reg_rdata[STAT_DONE_BIT]) begin
                        seq_d.stat  = reg_rdata;
                        seq_d.idx   = '0;
                        seq_d.state = seq_q.rd ? ST_OUT : ST_CLEAR;
                    end else if (seq_q.polls == POLL_LAST) begin
                        seq_d.state = ST_IDLE;
                        seq_d.done  = 1'b1;
                        seq_d.err   = 1'b1;
                    end else begin
                        seq_d.polls = seq_q.polls + 1'b1;
                        seq_d.state = ST_WAIT;
                        tmr_start   = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (tmr_expired) seq_d.state = ST_POLL;
            end
            ST_OUT: begin
                if (xfer_ok) begin
                    col_load = 1'b1;
                    if (seq_q.idx == IDX_LAST) begin
                        seq_d.state = ST_CLEAR;
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end
                end
            end
            ST_CLEAR: begin
                if (xfer_ok) begin
                    seq_d.state = ST_IDLE;
                    seq_d.done  = 1'b1;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase

        if (xfer_bad) begin
            seq_d.state = ST_IDLE;
            seq_d.done  = 1'b1;
            seq_d.err   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = (seq_q.state == ST_IDLE);
    assign reg_valid = acc_valid;
    assign reg_write = acc_write;
    assign reg_addr  = acc_addr;
    assign reg_wdata = acc_data;
    assign done      = seq_q.done;
    assign err       = seq_q.err;
endmodule

// File: rtl/mbox_seq_chk.sv
module mbox_seq_chk #(
    parameter int POLL_RETRIES = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       reg_valid,
    input logic       reg_write,
    input logic [7:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       reg_ack,
    input logic       reg_err,
    input logic       done,
    input logic       err
);
    logic [15:0] stat_reads_d, stat_reads_q;

    always_comb begin
        stat_reads_d = stat_reads_q;
        if (req_ready) begin
            stat_reads_d = '0;
        end else if (reg_valid && reg_ack && !reg_write && reg_addr == 8'h02) begin
            stat_reads_d = stat_reads_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_reads_q <= '0;
        else        stat_reads_q <= stat_reads_d;
    end

    assert_hold_until_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid && !reg_ack |=> reg_valid && $stable(reg_addr) && $stable(reg_write)
                                   && $stable(reg_wdata));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !reg_valid);

    assert_start_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid && reg_write && reg_addr == 8'h3F |-> reg_wdata == 8'h80);

    assert_ring_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid && reg_write && reg_addr == 8'h40 |-> reg_wdata == 8'h01);

    assert_poll_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_reads_q <= 16'(POLL_RETRIES + 1));

    assert_clear_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid && reg_write && reg_addr == 8'h02 |-> reg_wdata[1]);

    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid && reg_ack && reg_err |=> done && err && req_ready);

    assert_ctrl_unmask_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid && reg_write && reg_addr == 8'h01 |-> !reg_wdata[4]);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind mbox_seq mbox_seq_chk #(
    .POLL_RETRIES (POLL_RETRIES)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_ack   (reg_ack),
    .reg_err   (reg_err),
    .done      (done),
    .err       (err)
);

// File: tb/mbox_seq_tb_top.sv
module mbox_seq_tb_top;
    localparam int RETRIES = 4;
    localparam int WAITC   = 3;
    localparam int MAXLOG  = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_cmd = '0;
    logic        req_read = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        arm_req = 1'b0;
    logic        reg_valid, reg_write;
    logic [7:0]  reg_addr, reg_wdata;
    logic        reg_ack = 1'b0;
    logic [7:0]  reg_rdata = '0;
    logic        reg_err = 1'b0;
    logic        done, err;
    logic [31:0] rdata;

    always #2 clk = ~clk;

    mbox_seq #(
        .POLL_RETRIES (RETRIES),
        .POLL_WAIT    (WAITC)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_cmd   (req_cmd),
        .req_read  (req_read),
        .req_wdata (req_wdata),
        .arm_req   (arm_req),
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_ack   (reg_ack),
        .reg_rdata (reg_rdata),
        .reg_err   (reg_err),
        .done      (done),
        .err       (err),
        .rdata     (rdata)
    );

    int checks = 0;
    int errors = 0;

    // responder model state
    int         m_ready_after = 1;
    int         m_err_at = 0;
    logic [7:0] m_ctrl = '0;
    logic [7:0] m_out [4];
    int         m_acc = 0;
    int         m_stat_reads = 0;
    int         lat_seed = 0;
    int         cur_lat = 0;
    int         wait_cnt = 0;
    logic [7:0] log_addr [MAXLOG];
    logic       log_wr   [MAXLOG];
    logic [7:0] log_dat  [MAXLOG];
    int         log_n = 0;
    bit         gap_on = 0;
    int         gap_cur = 0;
    int         gap_min = 1000;
    int         gap_max = -1;

    logic [7:0] exp_addr [MAXLOG];
    logic       exp_wr   [MAXLOG];
    logic [7:0] exp_dat  [MAXLOG];
    int         exp_n = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    // register-port responder
    initial begin
        forever begin
            @(negedge clk);
            reg_ack   = 1'b0;
            reg_err   = 1'b0;
            reg_rdata = 8'h00;
            if (rst_n && reg_valid) begin
                if (gap_on) begin
                    if (!reg_write && reg_addr == 8'h02) begin
                        if (gap_cur < gap_min) gap_min = gap_cur;
                        if (gap_cur > gap_max) gap_max = gap_cur;
                    end
                    gap_on = 0;
                end
                if (wait_cnt < cur_lat) begin
                    wait_cnt++;
                end else begin
                    m_acc++;
                    if (log_n < MAXLOG) begin
                        log_addr[log_n] = reg_addr;
                        log_wr[log_n]   = reg_write;
                        log_dat[log_n]  = reg_wdata;
                    end
                    log_n++;
                    if (m_acc == m_err_at) reg_err = 1'b1;
                    if (!reg_write) begin
                        if (reg_addr == 8'h01) begin
                            reg_rdata = m_ctrl;
                        end else if (reg_addr == 8'h02) begin
                            m_stat_reads++;
                            reg_rdata = (m_ready_after != 0 && m_stat_reads >= m_ready_after)
                                        ? 8'h52 : 8'h50;
                            gap_on  = 1;
                            gap_cur = 0;
                        end else if (reg_addr >= 8'h31 && reg_addr <= 8'h34) begin
                            reg_rdata = m_out[reg_addr - 8'h31];
                        end
                    end
                    reg_ack  = 1'b1;
                    wait_cnt = 0;
                    cur_lat  = (m_acc + lat_seed) % 3;
                end
            end else if (rst_n && gap_on) begin
                gap_cur++;
            end
        end
    end

    task automatic add_exp(input logic [7:0] a, input logic w, input logic [7:0] d);
        exp_addr[exp_n] = a;
        exp_wr[exp_n]   = w;
        exp_dat[exp_n]  = d;
        exp_n++;
    endtask

    function automatic string tag_of(input logic [7:0] a, input logic w);
        if (a == 8'h02) return w ? "R9" : "R5";
        if (a >= 8'h31 && a <= 8'h34) return "R7";
        if (a == 8'h01) return "R11";
        return "R4";
    endfunction

    task automatic compare_trace(input string cnt_tag);
        chk(cnt_tag, 32'(log_n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            chk(tag_of(exp_addr[i], exp_wr[i]), {23'd0, log_wr[i], log_addr[i]},
                {23'd0, exp_wr[i], exp_addr[i]});
            if (exp_wr[i]) chk(tag_of(exp_addr[i], 1'b1), 32'(log_dat[i]), 32'(exp_dat[i]));
        end
    endtask

    task automatic prep_model(input int ra, input int ea, input int seed);
        m_ready_after = ra;
        m_err_at      = ea;
        m_acc         = 0;
        m_stat_reads  = 0;
        log_n         = 0;
        gap_on        = 0;
        gap_min       = 1000;
        gap_max       = -1;
        lat_seed      = seed;
        cur_lat       = seed % 3;
        wait_cnt      = 0;
        exp_n         = 0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            if (done) begin
                seen = 1;
                break;
            end
        end
    endtask

    task automatic finish_checks(input bit exp_err, input bit chk_rd, input logic [31:0] exp_rd,
                                 input string etag, input string rtag);
        bit seen;
        logic [31:0] rd_snap;
        logic        er_snap;
        wait_done(seen);
        chk("R12 done seen", 32'(seen), 32'd1);
        chk(etag, 32'(err), 32'(exp_err));
        if (chk_rd) chk(rtag, rdata, exp_rd);
        rd_snap = rdata;
        er_snap = err;
        @(negedge clk);
        chk("R12 done low", 32'(done), 32'd0);
        chk("R12 err hold", 32'(err), 32'(er_snap));
        chk("R12 rdata hold", rdata, rd_snap);
    endtask

    // full exchange with a computed expected trace
    task automatic run_txn(input logic [7:0] cmd, input bit rd, input logic [31:0] wd,
                           input int ra, input int ea, input int seed, input bit poke);
        bit ok;
        int nreads;
        bit exp_err;
        logic [31:0] exp_rd;
        string etag;
        prep_model(ra, ea, seed);
        for (int i = 0; i < 4; i++) m_out[i] = 8'((seed * 37 + i * 71 + 5) & 8'hFF);
        add_exp(8'h3F, 1, 8'h80);
        add_exp(8'h38, 1, cmd);
        for (int i = 0; i < 4; i++) add_exp(8'(8'h39 + i), 1, wd[8*i +: 8]);
        add_exp(8'h40, 1, 8'h01);
        ok = (ra >= 1 && ra <= RETRIES + 1);
        nreads = ok ? ra : RETRIES + 1;
        for (int k = 0; k < nreads; k++) add_exp(8'h02, 0, 8'h00);
        if (ok) begin
            if (rd) for (int i = 0; i < 4; i++) add_exp(8'(8'h31 + i), 0, 8'h00);
            add_exp(8'h02, 1, 8'h52);
        end
        exp_err = !ok;
        exp_rd  = (rd && ok) ? {m_out[3], m_out[2], m_out[1], m_out[0]} : 32'd0;
        etag    = ok ? "R9 err" : "R6 err";
        if (ea > 0 && ea <= exp_n) begin
            exp_n   = ea;
            exp_err = 1;
            etag    = "R10 err";
        end
        req_cmd   = cmd;
        req_read  = rd;
        req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            req_cmd   = 8'hEE;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        finish_checks(exp_err, !exp_err, exp_rd, etag, rd ? "R7 rdata" : "R8 rdata");
        compare_trace(ea > 0 ? "R10 count" : (ok ? "R3 count" : "R6 count"));
        if (!exp_err && ra >= 2) begin
            chk("R5 gap min", 32'(gap_min), 32'(WAITC + 1));
            chk("R5 gap max", 32'(gap_max), 32'(WAITC + 1));
        end
        if (poke) begin
            repeat (10) @(negedge clk);
            chk("R2 no extra access", 32'(log_n), 32'(exp_n));
        end
    endtask

    task automatic run_arm(input logic [7:0] ctrl, input int ea, input bit both);
        bit exp_err;
        prep_model(1, ea, 1);
        m_ctrl = ctrl;
        add_exp(8'h01, 0, 8'h00);
        if (ctrl[4]) add_exp(8'h01, 1, ctrl & 8'hEF);
        exp_err = 0;
        if (ea > 0 && ea <= exp_n) begin
            exp_n   = ea;
            exp_err = 1;
        end
        arm_req = 1'b1;
        if (both) begin
            req_valid = 1'b1;
            req_cmd   = 8'h01;
        end
        @(negedge clk);
        arm_req   = 1'b0;
        req_valid = 1'b0;
        finish_checks(exp_err, 0, 32'd0, ea > 0 ? "R10 arm err" : "R11 err", "R11");
        compare_trace(both ? "R13 count" : "R11 count");
        if (both) begin
            chk("R13 first access", 32'(log_addr[0]), 32'h01);
            repeat (10) @(negedge clk);
            chk("R13 request dropped", 32'(log_n), 32'(exp_n));
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_out[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 err", 32'(err), 32'd0);
        chk("R1 rdata", rdata, 32'd0);
        chk("R1 no access", 32'(reg_valid), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after release", 32'(reg_valid), 32'd0);

        // sweep commands and completion points (R4, R5, R7, R8, R9)
        for (int c = 1; c <= 4; c++) begin
            for (int ra = 1; ra <= RETRIES + 1; ra++) begin
                run_txn(8'(c), c != 2, 32'h0102_0304 * c ^ (32'hA5C3_0F00 + ra),
                        ra, 0, c * 7 + ra, 0);
            end
        end

        // R6 timeout, read and write forms
        run_txn(8'h03, 1, 32'hDEAD_BEEF, 0, 0, 2, 0);
        run_txn(8'h02, 0, 32'h0000_1234, RETRIES + 2, 0, 5, 0);

        // R10 error at every access position of a read exchange
        for (int e = 1; e <= 14; e++) begin
            run_txn(8'h01, 1, 32'h8765_4321, 2, e, e, 0);
        end

        // R2 request during a running exchange
        run_txn(8'h04, 1, 32'h55AA_33CC, 3, 0, 4, 1);

        // R11 arm sequence
        run_arm(8'h13, 0, 0);
        run_arm(8'h03, 0, 0);
        run_arm(8'hFF, 0, 0);
        run_arm(8'h13, 1, 0);
        run_arm(8'h13, 2, 0);
        // R13 priority of arm over request
        run_arm(8'h10, 0, 1);

        // R8 write exchange after a read exchange leaves rdata zero
        run_txn(8'h03, 1, 32'h1111_2222, 1, 0, 9, 0);
        run_txn(8'h02, 0, 32'h3333_4444, 1, 0, 10, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule